// File: doc/BRIEF.md
# Multi-Stream Strided Prefetcher

This block watches the addresses of cache misses and predicts which cache lines will be wanted next. It keeps a small table of streams, one per 4 KB page. A stream is opened by two misses that fall close together in one page. It is confirmed when a third miss continues the same line stride. From then on an issue engine sends prefetch requests along the stride until it is a fixed number of lines ahead of the most recent miss. A simpler mode ignores the table and asks for the next sequential line after every miss.

Requests leave through a four-entry queue with a valid/ready handshake. If the queue fills, the oldest waiting request is discarded rather than stalling the miss input. Addresses are byte addresses. Lines are 64 bytes, so every request has its six low bits clear.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset, `pf_valid` stays low until at least one miss has been presented.
- R2: With `obl_mode` high, a miss to line b (address bits 31:6) produces exactly one request for line b+1, provided b+1 lies in the same 4 KB page (address bits 31:12).
- R3: With `obl_mode` low, a stream is opened only when two successive misses are in the same 4 KB page and their line numbers differ by less than 4 (under 256 bytes). Misses 4 lines apart open nothing.
- R4: When an open stream with stride N (last miss line b+N) sees a miss on line b+2N, it issues lines b+3N, b+4N and onward in order, at most 12 lines of stride ahead of the latest miss. Each further miss continuing the stride releases one more request.
- R5: Strides are signed. A descending sequence of misses yields descending prefetch lines.
- R6: No request is ever produced for a line outside the page of the miss or stream that generated it.
- R7: A stride of zero (repeated misses to the same line) never confirms a stream and produces no request.
- R8: The table holds 8 streams. When all 8 are in use, opening a new stream evicts the least recently opened-or-hit stream, which then issues nothing.
- R9: The output queue holds 4 requests. When a request arrives while the queue is full and nothing leaves, the oldest is dropped. A waiting request keeps its address while `pf_ready` is low and nothing new arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| obl_mode | input | 1 | 1: next-line mode, 0: strided stream mode |
| miss_valid | input | 1 | A miss address is presented this cycle |
| miss_addr | input | 32 | Byte address of the miss |
| pf_valid | output | 1 | A prefetch request is waiting |
| pf_ready | input | 1 | Consumer accepts the request this cycle |
| pf_addr | output | 32 | Line-aligned byte address to prefetch |

## Verification
The properties assume that `obl_mode` changes only while no miss is pending, and that the consumer's `pf_ready` is a plain level sampled at the clock edge. The stimulus flips the mode once, between scenarios, with the miss input idle. Misses are spaced a few cycles apart so that the issue engine, which waits for miss-free cycles, can run. The hold property is conditioned on no new request arriving, because a push into a full queue is allowed to advance the head.

// File: rtl/stride_pf_pkg.sv
`timescale 1ns/1ps
package stride_pf_pkg;
    parameter int ADDR_W      = 32;
    parameter int LINE_SH     = 6;    // 64-byte lines
    parameter int PAGE_SH     = 12;   // 4 KB pages
    parameter int NSTREAM     = 8;
    parameter int MAX_AHEAD   = 12;
    parameter int ALLOC_BYTES = 256;
    parameter int QDEPTH      = 4;

    localparam int LINE_W  = ADDR_W - LINE_SH;
    localparam int PAGE_W  = ADDR_W - PAGE_SH;
    localparam int LIP_W   = PAGE_SH - LINE_SH;
    localparam int AHEAD_W = $clog2(MAX_AHEAD + 1);
    localparam int AGE_W   = $clog2(NSTREAM);
    localparam int WIN_LN  = ALLOC_BYTES >> LINE_SH;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [PAGE_W-1:0] page_t;

    typedef struct packed {
        logic               vld;
        logic               conf;
        page_t              page;
        line_t              last;
        line_t              stride;
        line_t              pf;
        logic [AHEAD_W-1:0] ahead;
        logic [AGE_W-1:0]   age;
    } stream_t;
endpackage

// File: rtl/pfq_fifo.sv
`timescale 1ns/1ps
module pfq_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t q_q, q_d;
    logic  pop;
    logic  full;

    always_comb begin
        q_d  = q_q;
        full = (q_q.cnt == CNT_W'(DEPTH));
        pop  = (q_q.cnt != '0) && pop_ready;
        if (pop) begin
            q_d.rd  = q_q.rd + 1'b1;
            q_d.cnt = q_q.cnt - 1'b1;
        end
        if (push) begin
            q_d.mem[q_q.wr] = push_data;
            q_d.wr          = q_q.wr + 1'b1;
            if (full && !pop) begin
                q_d.rd = q_q.rd + 1'b1;   // discard oldest
            end else begin
                q_d.cnt = q_d.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign out_valid = (q_q.cnt != '0);
    assign out_data  = q_q.mem[q_q.rd];
endmodule

// File: rtl/stride_tracker.sv
`timescale 1ns/1ps
module stride_tracker
    import stride_pf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  miss_valid,
    input  line_t miss_line,
    output logic  gen_valid,
    output line_t gen_line
);
    localparam int SEL_W = (NSTREAM > 1) ? $clog2(NSTREAM) : 1;
    localparam logic signed [LINE_W-1:0] WIN_S = LINE_W'(WIN_LN);

    typedef struct packed {
        stream_t [NSTREAM-1:0] tbl;
        logic                  prev_vld;
        line_t                 prev;
    } trk_t;

    trk_t q_q, q_d;

    page_t                    mpage;
    logic                     hit, have_free, touch, found;
    logic [SEL_W-1:0]         hidx, vidx, tidx;
    logic [AGE_W-1:0]         tage;
    line_t                    delta, dl;
    logic signed [LINE_W-1:0] sdelta;
    logic                     close;

    always_comb begin
        q_d       = q_q;
        gen_valid = 1'b0;
        gen_line  = '0;
        mpage     = miss_line[LINE_W-1:LIP_W];
        hit       = 1'b0;
        hidx      = '0;
        have_free = 1'b0;
        vidx      = '0;
        touch     = 1'b0;
        tidx      = '0;
        tage      = '0;
        found     = 1'b0;
        dl        = '0;

        for (int e = 0; e < NSTREAM; e++) begin
            if (!hit && q_q.tbl[e].vld && q_q.tbl[e].page == mpage) begin
                hit  = 1'b1;
                hidx = SEL_W'(e);
            end
        end
        for (int e = 0; e < NSTREAM; e++) begin
            if (!have_free && !q_q.tbl[e].vld) begin
                have_free = 1'b1;
                vidx      = SEL_W'(e);
            end
        end
        if (!have_free) begin
            for (int e = 0; e < NSTREAM; e++) begin
                if (q_q.tbl[e].age == AGE_W'(NSTREAM - 1)) vidx = SEL_W'(e);
            end
        end

        delta  = miss_line - q_q.prev;
        sdelta = $signed(delta);
        close  = q_q.prev_vld && (q_q.prev[LINE_W-1:LIP_W] == mpage) &&
                 (sdelta < WIN_S) && (sdelta > -WIN_S);

        if (en && miss_valid) begin
            q_d.prev     = miss_line;
            q_d.prev_vld = 1'b1;
            if (hit) begin
                dl = miss_line - q_q.tbl[hidx].last;
                if (q_q.tbl[hidx].stride != '0 && dl == q_q.tbl[hidx].stride) begin
                    if (!q_q.tbl[hidx].conf) begin
                        q_d.tbl[hidx].conf  = 1'b1;
                        q_d.tbl[hidx].pf    = miss_line + q_q.tbl[hidx].stride;
                        q_d.tbl[hidx].ahead = '0;
                    end else if (q_q.tbl[hidx].ahead != '0) begin
                        q_d.tbl[hidx].ahead = q_q.tbl[hidx].ahead - 1'b1;
                    end else begin
                        q_d.tbl[hidx].pf    = miss_line + q_q.tbl[hidx].stride;
                    end
                end else begin
                    q_d.tbl[hidx].stride = dl;
                    q_d.tbl[hidx].conf   = 1'b0;
                    q_d.tbl[hidx].ahead  = '0;
                end
                q_d.tbl[hidx].last = miss_line;
                touch = 1'b1;
                tidx  = hidx;
            end else if (close) begin
                q_d.tbl[vidx].vld    = 1'b1;
                q_d.tbl[vidx].conf   = 1'b0;
                q_d.tbl[vidx].page   = mpage;
                q_d.tbl[vidx].last   = miss_line;
                q_d.tbl[vidx].stride = delta;
                q_d.tbl[vidx].pf     = '0;
                q_d.tbl[vidx].ahead  = '0;
                touch = 1'b1;
                tidx  = vidx;
            end
        end else if (en) begin
            for (int e = 0; e < NSTREAM; e++) begin
                if (!found && q_q.tbl[e].vld && q_q.tbl[e].conf &&
                    q_q.tbl[e].ahead < AHEAD_W'(MAX_AHEAD) &&
                    q_q.tbl[e].pf[LINE_W-1:LIP_W] == q_q.tbl[e].page) begin
                    found          = 1'b1;
                    gen_valid      = 1'b1;
                    gen_line       = q_q.tbl[e].pf;
                    q_d.tbl[e].pf    = q_q.tbl[e].pf + q_q.tbl[e].stride;
                    q_d.tbl[e].ahead = q_q.tbl[e].ahead + 1'b1;
                end
            end
        end

        if (touch) begin
            tage = q_q.tbl[tidx].vld ? q_q.tbl[tidx].age : AGE_W'(NSTREAM - 1);
            for (int e = 0; e < NSTREAM; e++) begin
                if (SEL_W'(e) == tidx)
                    q_d.tbl[e].age = '0;
                else if (q_q.tbl[e].vld && q_q.tbl[e].age < tage)
                    q_d.tbl[e].age = q_q.tbl[e].age + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end
endmodule

// File: rtl/stride_prefetcher.sv
`timescale 1ns/1ps
module stride_prefetcher
    import stride_pf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obl_mode,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);
    line_t miss_line, gen_line, push_line, out_line;
    logic  gen_valid, page_end, fifo_push;
    logic  unused_offset;

    assign miss_line     = miss_addr[ADDR_W-1:LINE_SH];
    assign unused_offset = ^miss_addr[LINE_SH-1:0];
    assign page_end      = (miss_line[LIP_W-1:0] == '1);

    stride_tracker u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (!obl_mode),
        .miss_valid (miss_valid),
        .miss_line  (miss_line),
        .gen_valid  (gen_valid),
        .gen_line   (gen_line)
    );

    always_comb begin
        if (obl_mode) begin
            fifo_push = miss_valid && !page_end;
            push_line = miss_line + 1'b1;
        end else begin
            fifo_push = gen_valid;
            push_line = gen_line;
        end
    end

    pfq_fifo #(.DEPTH(QDEPTH), .W(LINE_W)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (push_line),
        .pop_ready (pf_ready),
        .out_valid (pf_valid),
        .out_data  (out_line)
    );

    assign pf_addr = {out_line, {LINE_SH{1'b0}}};
endmodule

// File: rtl/stride_prefetcher_chk.sv
`timescale 1ns/1ps
module stride_prefetcher_chk
    import stride_pf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              obl_mode,
    input logic              miss_valid,
    input logic [ADDR_W-1:0] miss_addr,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr,
    input logic              fifo_push
);
    logic seen_miss;
    logic unused_bits;
    assign unused_bits = ^{miss_addr[ADDR_W-1:PAGE_SH], miss_addr[LINE_SH-1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n)          seen_miss <= 1'b0;
        else if (miss_valid) seen_miss <= 1'b1;
    end

    // R1
    a_r1_quiet_until_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_miss |-> !pf_valid);

    // R2
    a_r2_next_line_queued: assert property (@(posedge clk) disable iff (!rst_n)
        obl_mode && miss_valid && (miss_addr[PAGE_SH-1:LINE_SH] != '1) |=> pf_valid);

    // R9
    a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready && !fifo_push |=> pf_valid && $stable(pf_addr));

    // R9
    a_r9_push_visible: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |=> pf_valid);
endmodule

bind stride_prefetcher stride_prefetcher_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .obl_mode   (obl_mode),
    .miss_valid (miss_valid),
    .miss_addr  (miss_addr),
    .pf_valid   (pf_valid),
    .pf_ready   (pf_ready),
    .pf_addr    (pf_addr),
    .fifo_push  (fifo_push)
);

// File: tb/stride_prefetcher_tb.sv
`timescale 1ns/1ps
module stride_prefetcher_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        obl_mode = 1'b1;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_addr = '0;
    logic        pf_valid;
    logic        pf_ready = 1'b1;
    logic [31:0] pf_addr;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    stride_prefetcher u_dut (
        .clk(clk), .rst_n(rst_n), .obl_mode(obl_mode),
        .miss_valid(miss_valid), .miss_addr(miss_addr),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
    );

    function automatic logic [31:0] la(int unsigned page, int line);
        return (32'(page) << 12) | (32'(line) << 6);
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic expect_line(int unsigned page, int line, string tag);
        exp_q.push_back(la(page, line));
        tag_q.push_back(tag);
    endtask

    task automatic miss(int unsigned page, int line);
        @(posedge clk); #2;
        miss_valid = 1'b1;
        miss_addr  = la(page, line) | 32'h24;
        @(posedge clk); #2;
        miss_valid = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic settle(string tag);
        repeat (40) @(posedge clk);
        check(exp_q.size() == 0, tag, "expected requests missing", 32'(exp_q.size()), 32'd0);
        exp_q.delete();
        tag_q.delete();
    endtask

    // monitor: scoreboard pop on each accepted request
    always @(negedge clk) begin
        if (rst_n && pf_valid && pf_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "unexpected request", pf_addr, 32'hxxxxxxxx);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(pf_addr == e, t, "request address", pf_addr, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pf_valid == 1'b0, "R1", "valid after reset", 32'(pf_valid), 32'd0);

        // R2: next-line mode, R6 page end suppressed
        expect_line(16, 8, "R2");  miss(16, 7);
        expect_line(16, 21, "R2"); miss(16, 20);
        expect_line(16, 63, "R2"); miss(16, 62);
        miss(16, 63);               // R6: would leave page
        settle("R2");

        // R9: queue overflow drops oldest; head held while stalled
        @(posedge clk); #2 pf_ready = 1'b0;
        for (int i = 0; i < 6; i++) miss(17, i);
        @(negedge clk);
        check(pf_valid && pf_addr == la(17, 3), "R9", "held head after drops", pf_addr, la(17, 3));
        for (int i = 3; i <= 6; i++) expect_line(17, i, "R9");
        @(posedge clk); #2 pf_ready = 1'b1;
        settle("R9");

        @(posedge clk); #2 obl_mode = 1'b0;

        // R4: ascending stride 1, run 12 ahead, then one more
        for (int i = 3; i <= 14; i++) expect_line(32, i, "R4");
        miss(32, 0); miss(32, 1); miss(32, 2);
        settle("R4");
        expect_line(32, 15, "R4");
        miss(32, 3);
        settle("R4");

        // R5: descending stride -2
        for (int i = 0; i < 12; i++) expect_line(33, 34 - 2 * i, "R5");
        miss(33, 40); miss(33, 38); miss(33, 36);
        settle("R5");

        // R6: stride 2 runs into page end
        for (int i = 56; i <= 62; i += 2) expect_line(34, i, "R6");
        miss(34, 50); miss(34, 52); miss(34, 54);
        settle("R6");

        // R3: 256 bytes apart opens nothing; 192 bytes apart does
        miss(35, 0); miss(35, 4); miss(35, 8);
        settle("R3");
        for (int i = 0; i < 12; i++) expect_line(36, 9 + 3 * i, "R3");
        miss(36, 0); miss(36, 3); miss(36, 6);
        settle("R3");

        // R7: zero stride never confirms
        miss(41, 5); miss(41, 5); miss(41, 5); miss(41, 5);
        settle("R7");

        // R8: nine streams, the oldest is evicted
        for (int p = 48; p <= 56; p++) begin
            miss(p, 0); miss(p, 1);
        end
        miss(48, 2);               // evicted: no request
        settle("R8");
        for (int i = 3; i <= 14; i++) expect_line(49, i, "R8");
        miss(49, 2);
        settle("R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule